// File: doc/BRIEF.md
# Timestamped Coincidence and Order Detector

The block judges whether a group of secondary events lined up in time with a reference event. Each clock cycle is one tick, and the tick's value comes in on a counter input. Whenever a secondary input rises, the block stores the tick value at which it rose. A judgement is made only in a tick in which the reference input rises. In that tick, each secondary input's most recent stamp is compared with the current tick against a lag programmed for that input. A lag of zero asks for the same tick, and a lag of k asks for exactly k ticks earlier.

One tick after a judgement, exactly one of two pulse outputs fires. The pass pulse means every relation held, and the fail pulse means at least one did not. Secondary inputs can be marked invariant. A failed relation on any marked input also sets a sticky alarm, which only reset clears. All inputs are treated as transient events: only a rising edge counts, and a level that stays high is never seen as a new event.

Top module: `tick_order_detector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, pass_o, fail_o and alarm_o are 0.
- R2: A judgement happens only in a cycle in which ref_i rises, meaning it is 1 now and was 0 in the previous cycle (during reset it counts as 0). The result appears on pass_o or fail_o in the following cycle. In all other cycles both outputs stay 0.
- R3: Secondary input i is a rising edge on sec_i[i]. Its lag field is lag_cfg_i[4*i+3:4*i]. With a lag of 0, input i passes only if it rose in the same cycle as ref_i.
- R4: With a lag k from 1 to 15, input i passes only if its most recent rise happened exactly k ticks before the judgement. The distance is measured as tick_i at the judgement minus tick_i at that rise.
- R5: A secondary input that has not risen since reset fails, whatever its lag.
- R6: A held level is not a new event. A ref_i held high causes one judgement only. A sec_i held high keeps the stamp of the tick in which it rose.
- R7: pass_o pulses when every secondary input passes, and fail_o pulses when any input fails. The two are never 1 together, and each pulse lasts one cycle.
- R8: When a judgement fails on an input whose inv_cfg_i bit is 1, alarm_o becomes 1 and stays 1 until reset. A failure only on inputs whose bit is 0 leaves alarm_o unchanged.
- R9: Tick distances are computed modulo 2^16, so a rise before the counter wraps and a judgement after it are compared correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one tick |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 16 | Current tick value |
| ref_i | input | 1 | Reference event input |
| sec_i | input | 4 | Secondary event inputs |
| lag_cfg_i | input | 16 | Required lag for each input, 4 bits each (0 = same tick) |
| inv_cfg_i | input | 4 | Invariant flag for each secondary input |
| pass_o | output | 1 | One-cycle pulse: all relations held |
| fail_o | output | 1 | One-cycle pulse: at least one relation failed |
| alarm_o | output | 1 | Sticky alarm for a failed invariant input |

## Verification
The hardest cases to reach are the ones where a stored stamp must stay untouched, or must line up across a counter wrap. These are a secondary input held high for several ticks before the reference rises, and a rise at tick 0xFFFE judged at tick 0x0001. The bench sets tick_i directly so it can place the wrap, and it holds levels across several steps so that a wrongly refreshed stamp turns a pass into a fail. A table of vectors places each secondary rise at a chosen distance before the reference, including inputs that never rise, so each lag can be matched or missed by one tick.

// File: rtl/tick_order_detector.sv
module tick_order_detector #(
  parameter int N  = 4,
  parameter int TW = 16,
  parameter int LW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   tick_i,
  input  logic            ref_i,
  input  logic [N-1:0]    sec_i,
  input  logic [N*LW-1:0] lag_cfg_i,
  input  logic [N-1:0]    inv_cfg_i,
  output logic            pass_o,
  output logic            fail_o,
  output logic            alarm_o
);

  logic          ref_q;
  logic [N-1:0]  sec_q, seen_q, ok;
  logic [TW-1:0] stamp_q [N];

  wire          ref_rise = ref_i & ~ref_q;
  wire [N-1:0]  sec_rise = sec_i & ~sec_q;
  wire          all_ok   = &ok;
  wire          inv_bad  = |(inv_cfg_i & ~ok);

  for (genvar i = 0; i < N; i++) begin : g_in
    wire [TW-1:0] stamp_eff = sec_rise[i] ? tick_i : stamp_q[i];
    wire [TW-1:0] age       = tick_i - stamp_eff;
    assign ok[i] = (sec_rise[i] | seen_q[i]) && (age == TW'(lag_cfg_i[i*LW +: LW]));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seen_q[i]  <= 1'b0;
        stamp_q[i] <= '0;
      end else if (sec_rise[i]) begin
        seen_q[i]  <= 1'b1;
        stamp_q[i] <= tick_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q   <= 1'b0;
      sec_q   <= '0;
      pass_o  <= 1'b0;
      fail_o  <= 1'b0;
      alarm_o <= 1'b0;
    end else begin
      ref_q   <= ref_i;
      sec_q   <= sec_i;
      pass_o  <= ref_rise & all_ok;
      fail_o  <= ref_rise & ~all_ok;
      alarm_o <= alarm_o | (ref_rise & inv_bad);
    end
  end

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o || fail_o) |=> !(pass_o || fail_o));
  assert_only_on_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_i && !ref_q) |=> !(pass_o || fail_o));
  assert_judged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_i && !ref_q) |=> (pass_o || fail_o));
  assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |=> alarm_o);
  assert_unseen_fails_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_i && !ref_q && !(|(seen_q | sec_rise))) |=> fail_o);

endmodule

// File: tb/tick_order_detector_tb.sv
`timescale 1ns/1ps
module tick_order_detector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tick_i = '0;
  logic        ref_i = 1'b0;
  logic [3:0]  sec_i = '0;
  logic [15:0] lag_cfg_i = '0;
  logic [3:0]  inv_cfg_i = '0;
  logic        pass_o, fail_o, alarm_o;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tick_order_detector u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ref_i(ref_i), .sec_i(sec_i),
    .lag_cfg_i(lag_cfg_i), .inv_cfg_i(inv_cfg_i),
    .pass_o(pass_o), .fail_o(fail_o), .alarm_o(alarm_o)
  );

  // {alarm, pass, inv[3:0], lag3..lag0 (4b), off3..off0 (5b, 31 = never)}
  localparam logic [41:0] VEC [8] = '{
    {1'b0, 1'b1, 4'b0000, 4'd0, 4'd0, 4'd0, 4'd0,  5'd0, 5'd0, 5'd0, 5'd0},
    {1'b1, 1'b0, 4'b1000, 4'd0, 4'd0, 4'd0, 4'd0,  5'd1, 5'd0, 5'd0, 5'd0},
    {1'b0, 1'b1, 4'b1111, 4'd0, 4'd15, 4'd1, 4'd3, 5'd0, 5'd15, 5'd1, 5'd3},
    {1'b0, 1'b0, 4'b0001, 4'd0, 4'd15, 4'd1, 4'd3, 5'd0, 5'd15, 5'd2, 5'd3},
    {1'b1, 1'b0, 4'b0001, 4'd0, 4'd0, 4'd0, 4'd2,  5'd0, 5'd0, 5'd0, 5'd31},
    {1'b0, 1'b1, 4'b0000, 4'd5, 4'd5, 4'd5, 4'd5,  5'd5, 5'd5, 5'd5, 5'd5},
    {1'b0, 1'b0, 4'b0000, 4'd5, 4'd5, 4'd5, 4'd5,  5'd5, 5'd5, 5'd5, 5'd4},
    {1'b0, 1'b0, 4'b0000, 4'd0, 4'd0, 4'd0, 4'd0,  5'd0, 5'd0, 5'd0, 5'd2}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [3:0] s);
    @(negedge clk);
    tick_i <= tick_i + 16'd1;
    ref_i  <= r;
    sec_i  <= s;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n <= 1'b0; ref_i <= 1'b0; sec_i <= '0;
    repeat (2) @(negedge clk);
    rst_n <= 1'b1;
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 pass in reset", pass_o, 1'b0);
    chk("R1 fail in reset", fail_o, 1'b0);
    chk("R1 alarm in reset", alarm_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pass after reset", pass_o, 1'b0);

    // table walk: R3 R4 R5 R7 R8
    for (int v = 0; v < 8; v++) begin
      do_reset();
      for (int i = 0; i < 4; i++) lag_cfg_i[i*4 +: 4] = VEC[v][20 + i*4 +: 4];
      inv_cfg_i = VEC[v][36 +: 4];
      for (int s = 20; s >= 0; s--) begin
        logic [3:0] bits;
        for (int i = 0; i < 4; i++) bits[i] = (VEC[v][i*5 +: 5] == 5'(s));
        step(s == 0, bits);
      end
      step(1'b0, 4'b0);
      chk("R3/R4 table pass", pass_o, VEC[v][40]);
      chk("R7 table fail", fail_o, ~VEC[v][40]);
      chk("R8 table alarm", alarm_o, VEC[v][41]);
    end

    // R2: secondary activity without a reference gives no output
    do_reset();
    lag_cfg_i = '0; inv_cfg_i = '0;
    for (int k = 0; k < 4; k++) begin
      step(1'b0, k[0] ? 4'hF : 4'h0);
      chk("R2 quiet pass", pass_o, 1'b0);
      chk("R2 quiet fail", fail_o, 1'b0);
    end

    // R6: reference held high judges once
    do_reset();
    step(1'b1, 4'hF);
    step(1'b1, 4'h0);
    chk("R6 held ref first pass", pass_o, 1'b1);
    step(1'b1, 4'h0);
    chk("R6 held ref no repeat pass", pass_o, 1'b0);
    chk("R6 held ref no repeat fail", fail_o, 1'b0);
    step(1'b0, 4'h0);
    chk("R7 pulse one cycle", pass_o, 1'b0);

    // R6: secondary held high keeps its original stamp
    do_reset();
    lag_cfg_i = {4{4'd3}};
    step(1'b0, 4'hF);
    step(1'b0, 4'hF);
    step(1'b0, 4'hF);
    step(1'b1, 4'hF);
    step(1'b0, 4'h0);
    chk("R6 held sec keeps stamp", pass_o, 1'b1);

    // R9: wrap of the tick counter
    do_reset();
    lag_cfg_i = {4{4'd3}};
    @(negedge clk);
    tick_i <= 16'hFFFD;
    step(1'b0, 4'hF);
    step(1'b0, 4'h0);
    step(1'b0, 4'h0);
    step(1'b1, 4'h0);
    step(1'b0, 4'h0);
    chk("R9 wrap pass", pass_o, 1'b1);
    chk("R9 wrap fail", fail_o, 1'b0);

    // R8: alarm survives a later passing judgement
    do_reset();
    lag_cfg_i = '0; inv_cfg_i = 4'b0010;
    step(1'b1, 4'b1101);
    step(1'b0, 4'h0);
    chk("R8 alarm set", alarm_o, 1'b1);
    step(1'b0, 4'h0);
    step(1'b1, 4'hF);
    step(1'b0, 4'h0);
    chk("R8 later pass", pass_o, 1'b1);
    chk("R8 alarm sticky", alarm_o, 1'b1);
    do_reset();
    @(negedge clk);
    chk("R1 alarm cleared by reset", alarm_o, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule